// File: doc/BRIEF.md
# Buffered Serial Transmitter with Busy Tracking

This block is the transmit half of an asynchronous serial port. Characters are written into a small queue. While transmission is enabled, the block takes the oldest character and sends it as a frame: one low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. It keeps sending frames until the queue is drained. A baud tick supplied from outside marks every bit boundary. The block does not generate that tick.

A busy flag covers both queued characters and the frame on the line. It drops only after the last stop bit has finished. It also stays up during a line break, which holds the output low for at least one frame time. Clearing the enable lets the frame already in flight finish. No new frame starts, and the busy flag stays up for as long as characters wait in the queue.

Top module: `fifo_uart_tx`

## Requirements
- R1: After reset the serial line is high, busy is low, the queue reports empty and not full, and the overflow flag is clear.
- R2: A frame starts on a baud tick. It has one low start bit followed by the data bits, least significant first. Each bit lasts one tick interval. The `word_len` code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, and unused upper bits of `wr_data` are not sent.
- R3: With `parity_en` set, a parity bit follows the data bits. With `parity_odd` 0, the data bits plus the parity bit hold an even number of ones. With `parity_odd` 1, they hold an odd number.
- R4: Every frame ends with one high stop bit, or with two when `two_stop` is 1.
- R5: Characters go out in the order they were written. While the enable is held and data remains queued, the next start bit follows the final stop bit with no idle bit between them.
- R6: Busy is high in every cycle in which the queue is nonempty, starting at the first clock edge after an accepted write.
- R7: Busy stays high through every bit of a frame, including the last stop bit. It goes low at the tick that ends that stop bit when nothing is left to send. Whenever busy is low, the line is high.
- R8: Clearing `tx_enable` in the middle of a frame lets that frame finish. No further frame starts, and busy stays high while characters remain queued.
- R9: A break request is taken at a tick when no frame is in flight, or when a frame has just ended, and it wins over starting a frame. The line is then held low while the request stays asserted, and for at least as many bit times as a frame with the current settings. Busy is high throughout, and the line returns high afterwards.
- R10: The queue holds 4 characters, and `fifo_full` is high when it holds 4. A write while full is dropped, even in a cycle in which a character is removed. A dropped write sets `overflow`, which stays set until reset.
- R11: The serial line changes only at clock edges where `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Character to queue |
| tx_enable | input | 1 | Allows new frames to start |
| word_len | input | 2 | Data bit count minus 5 |
| parity_en | input | 1 | Adds a parity bit |
| parity_odd | input | 1 | Selects odd parity when set, even when clear |
| two_stop | input | 1 | Selects two stop bits |
| brk_req | input | 1 | Requests a break (line held low) |
| baud_tick | input | 1 | Single-cycle pulse marking each bit boundary |
| tx_line | output | 1 | Serial output, idles high |
| fifo_full | output | 1 | Queue holds 4 characters |
| fifo_empty | output | 1 | Queue holds no characters |
| busy | output | 1 | Data queued, frame in flight, or break active |
| overflow | output | 1 | Sticky flag set by a dropped write |

## Verification
Two events can land in the same clock cycle. A write can reach the queue on the same tick edge at which the shifter takes the oldest character for the next frame. A break request can be pending at the tick that ends a frame while more data is still queued. Random bursts of writes with random gaps, made while frames are going out, produce the first case. A receiver model in the bench judges it by comparing every decoded character against the write order. The break case is driven directly, and it is judged by counting the low bit times and by watching busy across the break.

// File: rtl/fut_pkg.sv
package fut_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_BREAK = 2'd2
   } tx_state_e;
endpackage

// File: rtl/fut_fifo.sv
module fut_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty,
   output logic         ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         if (push_ok && !pop_ok)      count <= count + 1'b1;
         else if (pop_ok && !push_ok) count <= count - 1'b1;
         if (push && full) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/fut_framer.sv
module fut_framer #(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter int LEN_W  = 2,
   parameter int FW     = DATA_W + 4,
   parameter int CW     = $clog2(FW + 1)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LEN_W-1:0]  word_len,
   input  logic              parity_en,
   input  logic              parity_odd,
   input  logic              two_stop,
   output logic [FW-1:0]     frame,
   output logic [CW-1:0]     flen
);
   int          nbits;
   logic [DATA_W-1:0] mask;
   logic        par;

   always_comb begin
      nbits = MIN_W + int'(word_len);
      if (nbits > DATA_W) nbits = DATA_W;
      for (int i = 0; i < DATA_W; i++) mask[i] = (i < nbits);
      par   = (^(data & mask)) ^ parity_odd;
      frame = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
         if (i < nbits) frame[1 + i] = data[i];
      for (int i = 1; i < FW; i++)
         if (parity_en && i == nbits + 1) frame[i] = par;
      flen = CW'(nbits + 2 + int'(parity_en) + int'(two_stop));
   end
endmodule

// File: rtl/fut_shifter.sv
module fut_shifter
   import fut_pkg::*;
#(
   parameter int FW = 12,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          enable,
   input  logic          brk_req,
   input  logic          fifo_empty,
   input  logic [FW-1:0] frame_in,
   input  logic [CW-1:0] flen_in,
   output logic          pop,
   output logic          line,
   output logic          active
);
   tx_state_e     state;
   logic [FW-1:0] sr;
   logic [CW-1:0] cnt;
   logic          at_end, go_brk, go_frame;

   assign at_end   = (state == ST_IDLE) || (state == ST_FRAME && cnt <= CW'(1));
   assign go_brk   = tick && at_end && brk_req;
   assign go_frame = tick && at_end && !brk_req && enable && !fifo_empty;
   assign pop      = go_frame;
   assign active   = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sr    <= '1;
         cnt   <= '0;
         line  <= 1'b1;
      end else if (tick) begin
         if (go_brk) begin
            state <= ST_BREAK;
            cnt   <= flen_in;
            line  <= 1'b0;
         end else if (go_frame) begin
            state <= ST_FRAME;
            sr    <= frame_in;
            cnt   <= flen_in;
            line  <= frame_in[0];
         end else if (at_end) begin
            state <= ST_IDLE;
            line  <= 1'b1;
         end else if (state == ST_FRAME) begin
            sr   <= {1'b1, sr[FW-1:1]};
            cnt  <= cnt - 1'b1;
            line <= sr[1];
         end else if (cnt > CW'(1)) begin
            cnt <= cnt - 1'b1;
         end else if (!brk_req) begin
            state <= ST_IDLE;
            line  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx #(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter int DEPTH  = 4,
   localparam int LEN_W = (DATA_W > MIN_W) ? $clog2(DATA_W - MIN_W + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_enable,
   input  logic [LEN_W-1:0]  word_len,
   input  logic              parity_en,
   input  logic              parity_odd,
   input  logic              two_stop,
   input  logic              brk_req,
   input  logic              baud_tick,
   output logic              tx_line,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              busy,
   output logic              overflow
);
   localparam int FW = DATA_W + 4;
   localparam int CW = $clog2(FW + 1);

   generate
      if (MIN_W < 1 || DATA_W < MIN_W) begin : g_bad_width
         $error("fifo_uart_tx: MIN_W must be >= 1 and <= DATA_W");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("fifo_uart_tx: DEPTH must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] head;
   logic [FW-1:0]     frame;
   logic [CW-1:0]     flen;
   logic              pop, active;

   fut_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(pop),
      .dout(head), .full(fifo_full), .empty(fifo_empty), .ovf(overflow)
   );

   fut_framer #(.DATA_W(DATA_W), .MIN_W(MIN_W), .LEN_W(LEN_W), .FW(FW), .CW(CW)) u_framer (
      .data(head), .word_len(word_len), .parity_en(parity_en),
      .parity_odd(parity_odd), .two_stop(two_stop), .frame(frame), .flen(flen)
   );

   fut_shifter #(.FW(FW), .CW(CW)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .enable(tx_enable),
      .brk_req(brk_req), .fifo_empty(fifo_empty), .frame_in(frame),
      .flen_in(flen), .pop(pop), .line(tx_line), .active(active)
   );

   assign busy = !fifo_empty || active;
endmodule

// File: rtl/fifo_uart_tx_chk.sv
module fifo_uart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic baud_tick,
   input logic tx_line,
   input logic fifo_full,
   input logic fifo_empty,
   input logic busy,
   input logic overflow
);
   AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(tx_line)); // R11
   AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fifo_full) |=> overflow); // R10
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R10
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty)); // R10
   AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_empty |-> busy); // R6
   AST_QUIET_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_line); // R7
endmodule

bind fifo_uart_tx fifo_uart_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .baud_tick(baud_tick),
   .tx_line(tx_line), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
   .busy(busy), .overflow(overflow)
);

// File: tb/fifo_uart_tx_test.sv
module fifo_uart_tx_test;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       wr_en = 1'b0, tx_enable = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] word_len = 2'd3;
   logic       parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
   logic       brk_req = 1'b0, baud_tick = 1'b0;
   logic       tx_line, fifo_full, fifo_empty, busy, overflow;

   int checks = 0, errors = 0;
   bit tick_run = 1'b0, tick_seen = 1'b0, done = 1'b0;
   bit brk_mode = 1'b0, chk_b2b = 1'b0, expect_next = 1'b0, in_frame = 1'b0;
   int brk_low = 0, frames_done = 0, nb = 0;
   logic [15:0] shreg;
   logic [7:0]  exp_q[$];

   fifo_uart_tx uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_enable(tx_enable), .word_len(word_len), .parity_en(parity_en),
      .parity_odd(parity_odd), .two_stop(two_stop), .brk_req(brk_req),
      .baud_tick(baud_tick), .tx_line(tx_line), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .busy(busy), .overflow(overflow)
   );

   always #4 clk = ~clk;

   function automatic int nbits_of();
      return 5 + int'(word_len);
   endfunction

   function automatic logic [7:0] mask_of();
      return 8'((1 << nbits_of()) - 1);
   endfunction

   function automatic bit exp_par(input logic [7:0] d);
      return (^(d & mask_of())) ^ parity_odd;
   endfunction

   function automatic int frame_len();
      return 2 + nbits_of() + int'(parity_en) + int'(two_stop);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         baud_tick = tick_run;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   always @(posedge clk) tick_seen <= baud_tick;

   always @(negedge clk) begin
      if (tick_seen && rst_n) begin
         if (brk_mode) begin
            if (!tx_line) brk_low++;
         end else if (!in_frame) begin
            if (expect_next) begin
               chk(tx_line == 1'b0, "R5 back-to-back start", tx_line, 0);
               expect_next = 1'b0;
            end
            if (!tx_line) begin
               in_frame = 1'b1;
               nb = 0;
               shreg = '0;
               chk(busy, "R6 busy at start bit", busy, 1);
            end
         end else begin
            chk(busy, "R7 busy within frame", busy, 1);
            shreg[nb] = tx_line;
            nb++;
            if (nb == nbits_of() + int'(parity_en) + 1 + int'(two_stop)) begin
               logic [7:0] exp_d, got;
               got = shreg[7:0] & mask_of();
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2 unexpected frame", got, 0);
                  exp_d = '0;
               end else begin
                  exp_d = exp_q.pop_front();
                  chk(got == exp_d, "R2 data", got, exp_d);
               end
               if (parity_en)
                  chk(shreg[nbits_of()] == exp_par(exp_d), "R3 parity",
                      shreg[nbits_of()], exp_par(exp_d));
               chk(shreg[nbits_of() + int'(parity_en)] == 1'b1, "R4 stop 1",
                   shreg[nbits_of() + int'(parity_en)], 1);
               if (two_stop)
                  chk(shreg[nbits_of() + int'(parity_en) + 1] == 1'b1, "R4 stop 2",
                      shreg[nbits_of() + int'(parity_en) + 1], 1);
               frames_done++;
               if (chk_b2b && exp_q.size() > 0) expect_next = 1'b1;
               in_frame = 1'b0;
            end
         end
      end
   end

   task automatic put(input logic [7:0] d);
      @(negedge clk);
      while (fifo_full) @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      exp_q.push_back(d & mask_of());
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!tick_seen) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         finish_up();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(tx_line == 1'b1, "R1 line idle", tx_line, 1);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
      chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);
      chk(overflow == 1'b0, "R1 overflow", overflow, 0);

      // R10 / R6: fill with ticks stopped and transmitter disabled
      word_len = 2'd3; parity_en = 1'b1; parity_odd = 1'b0; two_stop = 1'b1;
      put(8'hA5);
      chk(busy == 1'b1, "R6 busy after write", busy, 1);
      chk(fifo_empty == 1'b0, "R6 nonempty after write", fifo_empty, 0);
      put(8'h3C); put(8'h01); put(8'hFE);
      chk(fifo_full == 1'b1, "R10 full at 4", fifo_full, 1);
      chk(overflow == 1'b0, "R10 no overflow yet", overflow, 0);
      wr_en = 1'b1; wr_data = 8'h77;
      @(negedge clk);
      wr_en = 1'b0;
      chk(overflow == 1'b1, "R10 overflow set", overflow, 1);
      chk(fifo_full == 1'b1, "R10 still full", fifo_full, 1);
      chk(tx_line == 1'b1, "R11 no change without tick", tx_line, 1);

      // R5: drain back to back, dropped byte must not appear
      chk_b2b = 1'b1;
      tx_enable = 1'b1;
      tick_run = 1'b1;
      wait_idle();
      chk(frames_done == 4, "R10 dropped write not sent", frames_done, 4);
      chk(busy == 1'b0 && tx_line == 1'b1, "R7 idle after drain", busy, 0);
      chk_b2b = 1'b0;

      // R8: enable cleared mid-frame
      word_len = 2'd0; parity_en = 1'b0; two_stop = 1'b0;
      tx_enable = 1'b0;
      put(8'h15); put(8'h0A);
      frames_done = 0;
      tx_enable = 1'b1;
      @(negedge clk);
      while (!in_frame) @(negedge clk);
      tx_enable = 1'b0;
      repeat (80) @(negedge clk);
      chk(frames_done == 1, "R8 in-flight frame completes", frames_done, 1);
      chk(busy == 1'b1, "R8 busy while data waits", busy, 1);
      chk(fifo_empty == 1'b0, "R8 second char held", fifo_empty, 0);
      chk(tx_line == 1'b1, "R8 line idle", tx_line, 1);
      tx_enable = 1'b1;
      wait_idle();
      chk(frames_done == 2, "R8 resumes after enable", frames_done, 2);

      // R9: break of minimum length
      word_len = 2'd3; parity_en = 1'b1; two_stop = 1'b1;
      brk_mode = 1'b1; brk_low = 0;
      brk_req = 1'b1;
      wait_ticks(5);
      chk(busy == 1'b1, "R9 busy in break", busy, 1);
      chk(tx_line == 1'b0, "R9 line low in break", tx_line, 0);
      brk_req = 1'b0;
      wait_idle();
      chk(brk_low == frame_len(), "R9 minimum break length", brk_low, frame_len());
      chk(tx_line == 1'b1, "R9 line high after break", tx_line, 1);

      // R9: long break follows request length
      brk_low = 0;
      brk_req = 1'b1;
      wait_ticks(20);
      brk_req = 1'b0;
      wait_idle();
      chk(brk_low >= 19, "R9 long break held", brk_low, 19);
      brk_mode = 1'b0;

      // R2/R3/R4/R5: random bursts with random configuration
      for (int b = 0; b < 250; b++) begin
         wait_idle();
         word_len   = 2'($urandom_range(0, 3));
         parity_en  = 1'($urandom_range(0, 1));
         parity_odd = 1'($urandom_range(0, 1));
         two_stop   = 1'($urandom_range(0, 1));
         for (int k = 0; k < int'($urandom_range(1, 6)); k++) begin
            put(8'($urandom));
            repeat ($urandom_range(0, 30)) @(negedge clk);
         end
      end
      wait_idle();
      chk(exp_q.size() == 0, "R5 all characters sent", exp_q.size(), 0);
      chk(overflow == 1'b1, "R10 overflow sticky", overflow, 1);
      done = 1'b1;
      finish_up();
   end
endmodule